// File: doc/BRIEF.md
# Bank-switched dual-port memory router

The block is a shared word memory split into four equal banks and reached from two independent ports, A and B. Each port has its own chip enable, write enable, address, write data and read data. Four bank-select inputs decide ownership, one per bank. At any moment each bank belongs to exactly one port, and a port can reach only the banks it owns. Because ownership comes from outside and not from arbitration, the ports never contend. They run fully in parallel whenever they address different banks.

Both ports use one clock. The upper two bits of a port address pick the bank and the lower bits pick the word inside it. The bank depth is a parameter, so a bench can use a small array. A read returns its data one cycle after it is issued. A read to a bank the port does not own returns zero and raises that port's error flag for that returned cycle. A write to such a bank has no effect.

Top module: `bdr_top`

## Requirements
- R1: The two most significant bits of a port address give the bank index (0 to 3). The remaining BANK_AW bits give the word offset inside that bank.
- R2: When bank_sel_i[b] is 1, bank b belongs to port A. When it is 0, bank b belongs to port B.
- R3: A cycle with ce=1 and we=1 to an owned bank stores the write data at the addressed word.
- R4: A cycle with ce=1 and we=0 to an owned bank drives that word on the port's rdata_o in the next cycle, with err_o=0.
- R5: A write to a bank the port does not own leaves the memory unchanged.
- R6: A read to a bank the port does not own gives rdata_o=0 and err_o=1 in the next cycle only. Writes never raise err_o.
- R7: While ce=0 the port makes no access: writes are dropped, and in the next cycle rdata_o=0 and err_o=0.
- R8: The two ports read and write at the same time without affecting each other, as long as they address different banks.
- R9: Any of the 16 bank_sel_i patterns works, which gives port A anywhere from zero to four banks.
- R10: While reset is active, rdata_o=0 and err_o=0 on both ports.
- R11: After a cycle with no read (a write or an idle cycle), rdata_o is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_sel_i | input | 4 | Ownership per bank: 1 gives the bank to port A, 0 to port B |
| pa_ce_i | input | 1 | Port A chip enable |
| pa_we_i | input | 1 | Port A write enable |
| pa_addr_i | input | BANK_AW+2 | Port A address: bank index in the top two bits |
| pa_wdata_i | input | DATA_W | Port A write data |
| pa_rdata_o | output | DATA_W | Port A read data, one cycle after the read |
| pa_err_o | output | 1 | Port A read to an unowned bank, aligned with rdata |
| pb_ce_i | input | 1 | Port B chip enable |
| pb_we_i | input | 1 | Port B write enable |
| pb_addr_i | input | BANK_AW+2 | Port B address: bank index in the top two bits |
| pb_wdata_i | input | DATA_W | Port B write data |
| pb_rdata_o | output | DATA_W | Port B read data, one cycle after the read |
| pb_err_o | output | 1 | Port B read to an unowned bank, aligned with rdata |

## Verification
All 16 ownership patterns are swept. For each pattern, both ports write every address in the same cycles, with port B always aimed at the bank whose index is port A's index with both bits flipped. Both ports then read every address back. Some of those writes land in owned banks and some in unowned banks, and a later unowned write covers a word that was written earlier by its owner. That separates writes that are dropped from writes that leak, and it shows that the bank index is decoded from the top bits. A pass with the chip enable low and junk write data follows, then a read-back. That pass separates a suppressed port from one that still writes or still returns data.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int unsigned BDR_NUM_BANKS = 4;
  localparam int unsigned BDR_BANK_W    = $clog2(BDR_NUM_BANKS);
endpackage

// File: rtl/bdr_port.sv
module bdr_port
  import bdr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BANK_AW = 8,
  parameter bit          OWNER_B = 1'b0,
  localparam int unsigned AW     = BANK_AW + BDR_BANK_W
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [BDR_NUM_BANKS-1:0]              bank_sel_i,
  input  logic                                  ce_i,
  input  logic                                  we_i,
  input  logic [AW-1:0]                         addr_i,
  input  logic [BDR_NUM_BANKS-1:0][DATA_W-1:0]  bank_rdata_i,
  output logic [BDR_NUM_BANKS-1:0]              acc_o,
  output logic [BANK_AW-1:0]                    off_o,
  output logic [DATA_W-1:0]                     rdata_o,
  output logic                                  err_o
);
  logic [BDR_NUM_BANKS-1:0] own_mask;
  logic [BDR_BANK_W-1:0]    bank_idx, bank_q;
  logic                     hit_owned, rd_ok_q, err_q;

  generate
    if (OWNER_B) begin : g_own_b
      assign own_mask = ~bank_sel_i;
    end else begin : g_own_a
      assign own_mask = bank_sel_i;
    end
  endgenerate

  assign bank_idx  = addr_i[AW-1 -: BDR_BANK_W];
  assign off_o     = addr_i[BANK_AW-1:0];
  assign hit_owned = own_mask[bank_idx];

  always_comb begin
    for (int b = 0; b < BDR_NUM_BANKS; b++) begin
      acc_o[b] = ce_i && (bank_idx == BDR_BANK_W'(b)) && own_mask[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ok_q <= 1'b0;
      err_q   <= 1'b0;
      bank_q  <= '0;
    end else begin
      rd_ok_q <= ce_i && !we_i && hit_owned;
      err_q   <= ce_i && !we_i && !hit_owned;
      bank_q  <= bank_idx;
    end
  end

  assign rdata_o = rd_ok_q ? bank_rdata_i[bank_q] : '0;
  assign err_o   = err_q;

  AST_ACC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc_o)); // R1
  AST_OWNED_READ_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !we_i && (bank_sel_i[bank_idx] == !OWNER_B)) |=> !err_o); // R4
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0)); // R6
  AST_WRITE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && we_i) |=> !err_o); // R6
  AST_CE_LOW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (!err_o && rdata_o == '0)); // R7
endmodule

// File: rtl/bdr_bank.sv
module bdr_bank #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BANK_AW = 8,
  localparam int unsigned DEPTH  = 1 << BANK_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_a_i,
  input  logic               pa_acc_i,
  input  logic               pa_we_i,
  input  logic [BANK_AW-1:0] pa_off_i,
  input  logic [DATA_W-1:0]  pa_wdata_i,
  input  logic               pb_acc_i,
  input  logic               pb_we_i,
  input  logic [BANK_AW-1:0] pb_off_i,
  input  logic [DATA_W-1:0]  pb_wdata_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0]  mem [DEPTH];
  logic               acc, we;
  logic [BANK_AW-1:0] off;
  logic [DATA_W-1:0]  wdata, rdata_q;

  // owner's request steers the bank
  assign acc   = sel_a_i ? pa_acc_i   : pb_acc_i;
  assign we    = sel_a_i ? pa_we_i    : pb_we_i;
  assign off   = sel_a_i ? pa_off_i   : pb_off_i;
  assign wdata = sel_a_i ? pa_wdata_i : pb_wdata_i;

  always_ff @(posedge clk_i) begin
    if (acc && we) mem[off] <= wdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (acc && !we) rdata_q <= mem[off];
  end

  assign rdata_o = rdata_q;

  AST_A_ACC_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_acc_i |-> sel_a_i); // R2
  AST_B_ACC_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_acc_i |-> !sel_a_i); // R2
endmodule

// File: rtl/bdr_top.sv
module bdr_top
  import bdr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BANK_AW = 8,
  localparam int unsigned AW     = BANK_AW + BDR_BANK_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BDR_NUM_BANKS-1:0] bank_sel_i,
  input  logic                     pa_ce_i,
  input  logic                     pa_we_i,
  input  logic [AW-1:0]            pa_addr_i,
  input  logic [DATA_W-1:0]        pa_wdata_i,
  output logic [DATA_W-1:0]        pa_rdata_o,
  output logic                     pa_err_o,
  input  logic                     pb_ce_i,
  input  logic                     pb_we_i,
  input  logic [AW-1:0]            pb_addr_i,
  input  logic [DATA_W-1:0]        pb_wdata_i,
  output logic [DATA_W-1:0]        pb_rdata_o,
  output logic                     pb_err_o
);
  logic [BDR_NUM_BANKS-1:0]             pa_acc, pb_acc;
  logic [BANK_AW-1:0]                   pa_off, pb_off;
  logic [BDR_NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;

  bdr_port #(.DATA_W(DATA_W), .BANK_AW(BANK_AW), .OWNER_B(1'b0)) u_port_a (
    .clk_i, .rst_ni, .bank_sel_i,
    .ce_i(pa_ce_i), .we_i(pa_we_i), .addr_i(pa_addr_i),
    .bank_rdata_i(bank_rdata), .acc_o(pa_acc), .off_o(pa_off),
    .rdata_o(pa_rdata_o), .err_o(pa_err_o)
  );

  bdr_port #(.DATA_W(DATA_W), .BANK_AW(BANK_AW), .OWNER_B(1'b1)) u_port_b (
    .clk_i, .rst_ni, .bank_sel_i,
    .ce_i(pb_ce_i), .we_i(pb_we_i), .addr_i(pb_addr_i),
    .bank_rdata_i(bank_rdata), .acc_o(pb_acc), .off_o(pb_off),
    .rdata_o(pb_rdata_o), .err_o(pb_err_o)
  );

  for (genvar b = 0; b < BDR_NUM_BANKS; b++) begin : g_bank
    bdr_bank #(.DATA_W(DATA_W), .BANK_AW(BANK_AW)) u_bank (
      .clk_i, .rst_ni,
      .sel_a_i   (bank_sel_i[b]),
      .pa_acc_i  (pa_acc[b]),
      .pa_we_i   (pa_we_i),
      .pa_off_i  (pa_off),
      .pa_wdata_i(pa_wdata_i),
      .pb_acc_i  (pb_acc[b]),
      .pb_we_i   (pb_we_i),
      .pb_off_i  (pb_off),
      .pb_wdata_i(pb_wdata_i),
      .rdata_o   (bank_rdata[b])
    );

    AST_BANK_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pa_acc[b] && pb_acc[b])); // R8
  end
endmodule

// File: tb/bdr_top_tb_top.sv
`timescale 1ns/1ps
module bdr_top_tb_top;
  localparam int BAW = 4;
  localparam int AW  = BAW + 2;
  localparam int NW  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel_r = '0;
  logic pa_ce = 0, pa_we = 0, pb_ce = 0, pb_we = 0;
  logic [AW-1:0] pa_addr = '0, pb_addr = '0;
  logic [15:0] pa_wd = '0, pb_wd = '0;
  logic [15:0] pa_rd, pb_rd;
  logic pa_err, pb_err;

  int checks = 0, failures = 0;
  logic [15:0] model [NW];
  logic        pend = 1'b0;
  string       ptag = "";
  logic [15:0] exp_ad, exp_bd;
  logic        exp_ae, exp_be;

  always #2.5 clk = ~clk;

  bdr_top #(.DATA_W(16), .BANK_AW(BAW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bank_sel_i(sel_r),
    .pa_ce_i(pa_ce), .pa_we_i(pa_we), .pa_addr_i(pa_addr), .pa_wdata_i(pa_wd),
    .pa_rdata_o(pa_rd), .pa_err_o(pa_err),
    .pb_ce_i(pb_ce), .pb_we_i(pb_we), .pb_addr_i(pb_addr), .pb_wdata_i(pb_wd),
    .pb_rdata_o(pb_rd), .pb_err_o(pb_err)
  );

  function automatic bit owns(input bit port_b, input logic [3:0] s, input logic [AW-1:0] a);
    logic [1:0] b = a[AW-1 -: 2];
    return port_b ? !s[b] : s[b];
  endfunction

  task automatic check(input string tag, input string port, input logic [15:0] d,
                       input logic e, input logic [15:0] ed, input logic ee);
    checks++;
    if (d !== ed || e !== ee) begin
      failures++;
      $display("FAIL %s port %s: rdata=%h err=%b expected rdata=%h err=%b",
               tag, port, d, e, ed, ee);
    end
  endtask

  task automatic cycle(input string tag, input logic [3:0] s,
                       input logic c0, input logic w0, input logic [AW-1:0] a0, input logic [15:0] d0,
                       input logic c1, input logic w1, input logic [AW-1:0] a1, input logic [15:0] d1);
    @(negedge clk);
    if (pend) begin
      check(ptag, "A", pa_rd, pa_err, exp_ad, exp_ae);
      check(ptag, "B", pb_rd, pb_err, exp_bd, exp_be);
    end
    exp_ad = 16'h0; exp_ae = 1'b0; exp_bd = 16'h0; exp_be = 1'b0;
    if (c0 && !w0) begin
      if (owns(1'b0, s, a0)) exp_ad = model[a0]; else exp_ae = 1'b1;
    end
    if (c1 && !w1) begin
      if (owns(1'b1, s, a1)) exp_bd = model[a1]; else exp_be = 1'b1;
    end
    if (c0 && w0 && owns(1'b0, s, a0)) model[a0] = d0;
    if (c1 && w1 && owns(1'b1, s, a1)) model[a1] = d1;
    pend = 1'b1; ptag = tag;
    sel_r = s;
    pa_ce = c0; pa_we = w0; pa_addr = a0; pa_wd = d0;
    pb_ce = c1; pb_we = w1; pb_addr = a1; pb_wd = d1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check("R10", "A", pa_rd, pa_err, 16'h0, 1'b0);
    check("R10", "B", pb_rd, pb_err, 16'h0, 1'b0);
    rst_n = 1'b1;

    // R9 R2: every ownership pattern; B targets bank index ^ 3 (R8)
    for (int s = 0; s < 16; s++) begin
      for (int a = 0; a < NW; a++) begin
        cycle("R3 R5 R11", 4'(s),
              1'b1, 1'b1, AW'(a),        16'(s * 4099 + a * 37 + 11),
              1'b1, 1'b1, AW'(a) ^ 6'h30, 16'(s * 2731 + a * 53 + 7));
      end
      for (int a = 0; a < NW; a++) begin
        cycle("R1 R4 R6 R8 R9", 4'(s),
              1'b1, 1'b0, AW'(a),        16'h0,
              1'b1, 1'b0, AW'(a) ^ 6'h30, 16'h0);
      end
    end

    // R7: chip enable low drops writes and returns nothing
    for (int a = 0; a < NW; a++) begin
      cycle("R7", 4'b1010, 1'b0, 1'b1, AW'(a), 16'hdead,
                           1'b0, 1'b1, AW'(a) ^ 6'h30, 16'hbeef);
    end
    for (int a = 0; a < NW; a++) begin
      cycle("R7 R4", 4'b1010, 1'b1, 1'b0, AW'(a), 16'h0,
                              1'b1, 1'b0, AW'(a) ^ 6'h30, 16'h0);
    end
    cycle("R11", 4'b1010, 1'b0, 1'b0, '0, 16'h0, 1'b0, 1'b0, '0, 16'h0);
    cycle("R11", 4'b1010, 1'b0, 1'b0, '0, 16'h0, 1'b0, 1'b0, '0, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule